// File: doc/BRIEF.md
# Spread-Spectrum Frequency Offset Profile Generator

This block drives the modulation side of a spread-spectrum clock synthesizer. Running on the reference clock, it produces a signed offset word that a fractional-N feedback divider adds to its nominal multiplier. The offset traces a slow symmetric triangle, so the synthesized clock sweeps a narrow band instead of sitting on one frequency, and its peak spectral energy falls. The block also reports the nominal multiplier for the selected code, flags whether the code sweeps downward only or is not a valid code, and gates the enables of the modulated and reference clock outputs.

A 3-bit select code picks the multiplier, the spread depth and the spread style. In centre style the sweep is symmetric about the programmed average. In downward style the sweep runs only below the maximum frequency and never above it. A new select value is taken only at the profile origin, so the frequency never jumps in mid-sweep. A rising edge on an asynchronous restart pin returns the profile to its origin, which lets several generators share a common sweep phase. Power-down clears both output enables, and they come back only after a lock wait.

Top module: `sweep_offset_gen`

## Requirements
- R1: While `rst_n` is low, `offset_o` is 0, both output enables are 0, and the active code is 000 (`ratio_o` = 512, `down_mode_o` = 0, `code_bad_o` = 0).
- R2: Centre codes 000 (2.5 %), 001 (1.5 %), 010 (2.5 %) and 011 (2.5 %) use stride S = floor(floor(bp·65536/20000)/Q), with bp the total spread in hundredths of a percent and Q = `QSTEPS`. The profile takes one step every `STEP_DIV` cycles. After k steps from the origin, with p = k mod 4Q, the offset is p·S for p ≤ Q, (2Q−p)·S for p ≤ 3Q, and (p−4Q)·S otherwise.
- R3: Down codes 100 and 110 (2 %) use stride S = floor(floor(200·65536/10000)/(2Q)). The offset is −p·S for p ≤ 2Q and (p−4Q)·S otherwise. It is never positive, and `down_mode_o` is 1.
- R4: Codes 101 and 111 are reserved. While one of them is active, `offset_o` stays 0, `code_bad_o` is 1 and `ratio_o` is 0.
- R5: `ratio_o` is the nominal multiplier for the active code, in unsigned fixed point with 8 fraction bits. The values are 512, 512, 512 and 256 for codes 000 to 011, 1192 for 100 and 1788 for 110.
- R6: While `spread_en_n_i` is high, `offset_o` is 0 in the same cycle, the profile is held at its origin, and `fsel_i` is taken as the active code on every clock edge. After `spread_en_n_i` goes low, the sweep starts from the origin.
- R7: A low-to-high change on `restart_i` passes through two synchronizer flops. On the third clock edge after the change, the profile is at its origin and `fsel_i` is taken as the active code. Until then the sweep continues undisturbed.
- R8: While the sweep runs, a change on `fsel_i` takes effect only at the step that completes a full period (4Q steps). Until that step, the offset and `ratio_o` follow the previous code.
- R9: The first clock edge that samples `pwr_dn_n_i` low clears both output enables. After `pwr_dn_n_i` returns high, the enables stay low for `LOCK_CYC`−1 edges and become allowed on edge `LOCK_CYC`. The same wait applies after reset.
- R10: Once locked, `ref_oe_o` equals the inverse of `ref_en_n_i`, and `mod_oe_o` is 0 exactly when `test_i` and `ref_en_n_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsel_i | input | 3 | Frequency/spread select code |
| spread_en_n_i | input | 1 | Active-low spread enable |
| pwr_dn_n_i | input | 1 | Active-low power-down |
| restart_i | input | 1 | Asynchronous profile restart, rising edge |
| ref_en_n_i | input | 1 | Active-low reference output enable |
| test_i | input | 1 | Test input; with ref_en_n_i high, disables the modulated output |
| offset_o | output | OFS_W | Signed offset, units of 1/65536 of the nominal ratio |
| ratio_o | output | RATIO_W | Nominal multiplier, RATIO_FRAC fraction bits |
| down_mode_o | output | 1 | Active code is downward-only spread |
| code_bad_o | output | 1 | Active code is reserved |
| mod_oe_o | output | 1 | Modulated clock output enable |
| ref_oe_o | output | 1 | Reference clock output enable |

## Verification
The bench builds the block with `QSTEPS` = 4 and `STEP_DIV` = 2, so a full triangle period lasts 32 clocks. Every code, the sweep peaks, the period wrap and a code change across a wrap are therefore all reached within a few hundred cycles. At these values the strides are 204, 122 and 163, large enough that a wrong step direction or a wrong stride shows up in the very next sample. `LOCK_CYC` stays at 4 and two synchronizer stages are kept, so the lock wait and the restart latency can be counted edge by edge.

// File: rtl/ssg_pkg.sv
package ssg_pkg;

   typedef enum logic [1:0] {
      STYLE_NONE   = 2'd0,
      STYLE_CENTRE = 2'd1,
      STYLE_DOWN   = 2'd2
   } spread_style_e;

   localparam int unsigned NCODES = 8;

   function automatic spread_style_e style_of(int unsigned c);
      case (c)
         0, 1, 2, 3: return STYLE_CENTRE;
         4, 6:       return STYLE_DOWN;
         default:    return STYLE_NONE;
      endcase
   endfunction

   // total spread band, hundredths of a percent
   function automatic int unsigned spread_bp(int unsigned c);
      case (c)
         1:       return 150;
         4, 6:    return 200;
         0, 2, 3: return 250;
         default: return 0;
      endcase
   endfunction

   // nominal output/reference ratio, rounded to frac fraction bits
   function automatic longint ratio_of(int unsigned c, int unsigned frac);
      longint num;
      longint den;
      case (c)
         0, 1, 2: begin num = 2;      den = 1;     end
         3:       begin num = 1;      den = 1;     end
         4:       begin num = 66660;  den = 14318; end
         6:       begin num = 100000; den = 14318; end
         default: begin num = 0;      den = 1;     end
      endcase
      return ((num << frac) + den / 2) / den;
   endfunction

   // per-step offset increment for a profile of 4*q steps
   function automatic longint stride_of(int unsigned c, int unsigned q, int unsigned scale);
      longint span;
      span = (longint'(spread_bp(c)) << scale);
      case (style_of(c))
         STYLE_CENTRE: return (span / 20000) / q;
         STYLE_DOWN:   return (span / 10000) / (2 * q);
         default:      return 0;
      endcase
   endfunction

   // largest offset magnitude reached by a code
   function automatic longint peak_of(int unsigned c, int unsigned q, int unsigned scale);
      if (style_of(c) == STYLE_DOWN) return stride_of(c, q, scale) * 2 * q;
      return stride_of(c, q, scale) * q;
   endfunction

endpackage

// File: rtl/ssg_pin_rise.sv
module ssg_pin_rise #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o
);
   initial begin
      assert (STAGES >= 2) else $error("ssg_pin_rise: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= pin_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b0;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ssg_code_map.sv
module ssg_code_map
   import ssg_pkg::*;
#(
   parameter int unsigned QSTEPS     = 32,
   parameter int unsigned SCALE_BITS = 16,
   parameter int unsigned OFS_W      = 16,
   parameter int unsigned RATIO_W    = 16,
   parameter int unsigned RATIO_FRAC = 8
) (
   input  logic [2:0]              code_i,
   output logic signed [OFS_W-1:0] stride_o,
   output logic [RATIO_W-1:0]      ratio_o,
   output logic                    down_o,
   output logic                    bad_o
);
   localparam longint OFS_MAX   = (longint'(1) << (OFS_W - 1)) - 1;
   localparam longint RATIO_MAX = (longint'(1) << RATIO_W) - 1;

   initial begin
      assert (QSTEPS >= 1) else $error("ssg_code_map: QSTEPS must be positive");
      for (int c = 0; c < NCODES; c++) begin
         assert (peak_of(c, QSTEPS, SCALE_BITS) <= OFS_MAX)
            else $error("ssg_code_map: peak offset does not fit OFS_W");
         assert (ratio_of(c, RATIO_FRAC) <= RATIO_MAX)
            else $error("ssg_code_map: ratio does not fit RATIO_W");
      end
   end

   logic [OFS_W-1:0]   stride_tab [NCODES];
   logic [RATIO_W-1:0] ratio_tab  [NCODES];
   logic [NCODES-1:0]  down_tab;
   logic [NCODES-1:0]  bad_tab;

   genvar g;
   generate
      for (g = 0; g < NCODES; g++) begin : g_code
         assign stride_tab[g] = OFS_W'(stride_of(g, QSTEPS, SCALE_BITS));
         assign ratio_tab[g]  = RATIO_W'(ratio_of(g, RATIO_FRAC));
         assign down_tab[g]   = (style_of(g) == STYLE_DOWN);
         assign bad_tab[g]    = (style_of(g) == STYLE_NONE);
      end
   endgenerate

   assign stride_o = $signed(stride_tab[code_i]);
   assign ratio_o  = ratio_tab[code_i];
   assign down_o   = down_tab[code_i];
   assign bad_o    = bad_tab[code_i];
endmodule

// File: rtl/ssg_tri_acc.sv
module ssg_tri_acc #(
   parameter int unsigned OFS_W    = 16,
   parameter int unsigned QSTEPS   = 32,
   parameter int unsigned STEP_DIV = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hold_i,
   input  logic                    restart_i,
   input  logic                    down_i,
   input  logic signed [OFS_W-1:0] stride_i,
   output logic signed [OFS_W-1:0] acc_o,
   output logic                    wrap_o
);
   localparam int unsigned NPH   = 4 * QSTEPS;
   localparam int unsigned PH_W  = $clog2(NPH);
   localparam int unsigned DIV_W = $clog2(STEP_DIV);
   localparam logic [PH_W-1:0]  PH_Q    = PH_W'(QSTEPS);
   localparam logic [PH_W-1:0]  PH_2Q   = PH_W'(2 * QSTEPS);
   localparam logic [PH_W-1:0]  PH_3Q   = PH_W'(3 * QSTEPS);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(NPH - 1);
   localparam logic [DIV_W-1:0] DIV_END = DIV_W'(STEP_DIV - 1);

   initial begin
      assert (STEP_DIV >= 2) else $error("ssg_tri_acc: STEP_DIV must be at least 2");
      assert (QSTEPS >= 1)   else $error("ssg_tri_acc: QSTEPS must be positive");
   end

   logic [DIV_W-1:0]        div_q;
   logic [PH_W-1:0]         ph_q;
   logic signed [OFS_W-1:0] acc_q;
   logic                    step;
   logic                    go_up;

   assign step  = (div_q == DIV_END);
   assign go_up = down_i ? (ph_q >= PH_2Q) : ((ph_q < PH_Q) || (ph_q >= PH_3Q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         ph_q  <= '0;
         acc_q <= '0;
      end else if (hold_i || restart_i) begin
         div_q <= '0;
         ph_q  <= '0;
         acc_q <= '0;
      end else if (step) begin
         div_q <= '0;
         ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
         acc_q <= go_up ? acc_q + stride_i : acc_q - stride_i;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign acc_o  = acc_q;
   assign wrap_o = step && (ph_q == PH_LAST) && !hold_i && !restart_i;

   // R2: the sweep stays inside the band of the active stride
   assert_acc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(acc_q) <= int'(stride_i) * int'(QSTEPS)) &&
      (int'(acc_q) >= -2 * int'(QSTEPS) * int'(stride_i)));

   // R2: a running sweep never moves by more than one stride per cycle
   assert_step_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !restart_i) |=>
         ((int'(acc_q) - int'($past(acc_q)) <= int'($past(stride_i))) &&
          (int'($past(acc_q)) - int'(acc_q) <= int'($past(stride_i)))));

   // R3: a downward-only profile never rises above the maximum frequency
   assert_down_nonpos_R3: assert property (@(posedge clk) disable iff (!rst_n)
      down_i |-> (int'(acc_q) <= 0));

   // R7: a detected restart puts the profile back at its origin
   assert_restart_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (acc_q == '0) && (ph_q == '0) && (div_q == '0));
endmodule

// File: rtl/ssg_out_gate.sv
module ssg_out_gate #(
   parameter int unsigned LOCK_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn_n_i,
   input  logic ref_en_n_i,
   input  logic test_i,
   output logic mod_oe_o,
   output logic ref_oe_o
);
   localparam int unsigned LK_W = $clog2(LOCK_CYC + 1);
   localparam logic [LK_W-1:0] LK_END = LK_W'(LOCK_CYC);

   initial begin
      assert (LOCK_CYC >= 1) else $error("ssg_out_gate: LOCK_CYC must be positive");
   end

   logic [LK_W-1:0] lk_q;
   logic            locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               lk_q <= '0;
      else if (!pwr_dn_n_i)     lk_q <= '0;
      else if (lk_q != LK_END)  lk_q <= lk_q + 1'b1;
   end

   assign locked   = (lk_q == LK_END);
   assign ref_oe_o = locked && !ref_en_n_i;
   assign mod_oe_o = locked && !(test_i && ref_en_n_i);

   // R9: sampling power-down clears both enables on the next cycle
   assert_pd_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n_i |=> (!mod_oe_o && !ref_oe_o));
endmodule

// File: rtl/sweep_offset_gen.sv
module sweep_offset_gen
   import ssg_pkg::*;
#(
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned SCALE_BITS  = 16,
   parameter int unsigned RATIO_W     = 16,
   parameter int unsigned RATIO_FRAC  = 8,
   parameter int unsigned QSTEPS      = 32,
   parameter int unsigned STEP_DIV    = 8,
   parameter int unsigned LOCK_CYC    = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         fsel_i,
   input  logic               spread_en_n_i,
   input  logic               pwr_dn_n_i,
   input  logic               restart_i,
   input  logic               ref_en_n_i,
   input  logic               test_i,
   output logic [OFS_W-1:0]   offset_o,
   output logic [RATIO_W-1:0] ratio_o,
   output logic               down_mode_o,
   output logic               code_bad_o,
   output logic               mod_oe_o,
   output logic               ref_oe_o
);
   initial begin
      assert (OFS_W >= 8 && OFS_W <= 31) else $error("sweep_offset_gen: OFS_W out of range");
      assert (SCALE_BITS <= 24)          else $error("sweep_offset_gen: SCALE_BITS too large");
   end

   logic [2:0]              code_q;
   logic                    hold;
   logic                    restart;
   logic                    wrap;
   logic signed [OFS_W-1:0] stride;
   logic signed [OFS_W-1:0] acc;
   logic                    down;
   logic                    bad;
   logic [OFS_W-1:0]        ofs_next;

   assign hold = spread_en_n_i;

   ssg_pin_rise #(.STAGES(SYNC_STAGES)) u_restart (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (restart_i),
      .rise_o (restart)
   );

   // active code is only replaced at the profile origin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      code_q <= 3'd0;
      else if (hold || restart || wrap) code_q <= fsel_i;
   end

   ssg_code_map #(
      .QSTEPS     (QSTEPS),
      .SCALE_BITS (SCALE_BITS),
      .OFS_W      (OFS_W),
      .RATIO_W    (RATIO_W),
      .RATIO_FRAC (RATIO_FRAC)
   ) u_map (
      .code_i   (code_q),
      .stride_o (stride),
      .ratio_o  (ratio_o),
      .down_o   (down),
      .bad_o    (bad)
   );

   ssg_tri_acc #(
      .OFS_W    (OFS_W),
      .QSTEPS   (QSTEPS),
      .STEP_DIV (STEP_DIV)
   ) u_tri (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_i    (hold),
      .restart_i (restart),
      .down_i    (down),
      .stride_i  (stride),
      .acc_o     (acc),
      .wrap_o    (wrap)
   );

   ssg_out_gate #(.LOCK_CYC(LOCK_CYC)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_dn_n_i (pwr_dn_n_i),
      .ref_en_n_i (ref_en_n_i),
      .test_i     (test_i),
      .mod_oe_o   (mod_oe_o),
      .ref_oe_o   (ref_oe_o)
   );

   assign ofs_next = (hold || bad) ? '0 : acc;

   generate
      if (REG_OUT) begin : g_reg_out
         logic [OFS_W-1:0] ofs_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ofs_q <= '0;
            else        ofs_q <= ofs_next;
         end
         assign offset_o = ofs_q;
      end else begin : g_comb_out
         assign offset_o = ofs_next;
      end
   endgenerate

   assign down_mode_o = down;
   assign code_bad_o  = bad;

   // R4: a reserved code never lets the sweep leave zero
   assert_reserved_flat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bad |-> (acc == '0));

   // R6: while spread is disabled the profile sits at its origin
   assert_hold_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (acc == '0));
endmodule

// File: tb/sweep_offset_gen_tb.sv
module sweep_offset_gen_tb;
   localparam int Q  = 4;
   localparam int SD = 2;
   localparam int LK = 4;
   localparam int PERIOD = 4 * Q * SD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  fsel = 3'd0;
   logic        spread_en_n = 1'b0;
   logic        pwr_dn_n = 1'b1;
   logic        restart = 1'b0;
   logic        ref_en_n = 1'b0;
   logic        test = 1'b0;
   logic [15:0] offset;
   logic [15:0] ratio;
   logic        down_mode, code_bad, mod_oe, ref_oe;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sweep_offset_gen #(
      .QSTEPS   (Q),
      .STEP_DIV (SD),
      .LOCK_CYC (LK)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .fsel_i        (fsel),
      .spread_en_n_i (spread_en_n),
      .pwr_dn_n_i    (pwr_dn_n),
      .restart_i     (restart),
      .ref_en_n_i    (ref_en_n),
      .test_i        (test),
      .offset_o      (offset),
      .ratio_o       (ratio),
      .down_mode_o   (down_mode),
      .code_bad_o    (code_bad),
      .mod_oe_o      (mod_oe),
      .ref_oe_o      (ref_oe)
   );

   function automatic int tb_stride(int code);
      case (code)
         0, 2, 3: return ((250 * 65536) / 20000) / Q;
         1:       return ((150 * 65536) / 20000) / Q;
         4, 6:    return ((200 * 65536) / 10000) / (2 * Q);
         default: return 0;
      endcase
   endfunction

   function automatic int tb_ratio(int code);
      case (code)
         0, 1, 2: return 512;
         3:       return 256;
         4:       return 1192;
         6:       return 1788;
         default: return 0;
      endcase
   endfunction

   function automatic bit tb_down(int code);
      return (code == 4) || (code == 6);
   endfunction

   function automatic int tb_exp(int code, int n);
      int p;
      int st;
      p  = (n / SD) % (4 * Q);
      st = tb_stride(code);
      if (tb_down(code)) begin
         if (p <= 2 * Q) return -p * st;
         return (p - 4 * Q) * st;
      end
      if (p <= Q)     return p * st;
      if (p <= 3 * Q) return (2 * Q - p) * st;
      return (p - 4 * Q) * st;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // park in hold with a code, then release; the sweep starts at the origin
   task automatic start_code(input int code);
      spread_en_n = 1'b1;
      fsel = 3'(code);
      #1;
      chk("R6 offset zero while disabled", int'($signed(offset)), 0);
      tick();
      spread_en_n = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) tick();
      chk("R1 offset in reset", int'($signed(offset)), 0);
      chk("R1 mod_oe in reset", int'(mod_oe), 0);
      chk("R1 ref_oe in reset", int'(ref_oe), 0);
      chk("R1 ratio in reset", int'(ratio), 512);
      chk("R1 code_bad in reset", int'(code_bad), 0);
      chk("R1 down_mode in reset", int'(down_mode), 0);
      rst_n = 1'b1;
   endtask

   // sweep after reset with code 000, plus the lock wait (R2, R9)
   task automatic t_centre_after_reset();
      for (int n = 1; n <= 40; n++) begin
         tick();
         chk("R2 centre sweep 000", int'($signed(offset)), tb_exp(0, n));
         if (n == LK - 1) chk("R9 enable before lock", int'(mod_oe), 0);
         if (n == LK)     chk("R9 enable at lock", int'(mod_oe), 1);
      end
   endtask

   task automatic t_code(input int code);
      start_code(code);
      chk("R5 ratio for code", int'(ratio), tb_ratio(code));
      chk("R3 down flag for code", int'(down_mode), int'(tb_down(code)));
      chk("R4 reserved flag for code", int'(code_bad), int'(tb_ratio(code) == 0));
      for (int n = 1; n <= 34; n++) begin
         tick();
         if (tb_ratio(code) == 0)
            chk("R4 reserved offset", int'($signed(offset)), 0);
         else if (tb_down(code)) begin
            chk("R3 down sweep", int'($signed(offset)), tb_exp(code, n));
            if (int'($signed(offset)) > 0) chk("R3 never positive", int'($signed(offset)), 0);
         end else
            chk("R2 centre sweep", int'($signed(offset)), tb_exp(code, n));
      end
   endtask

   // code change mid-period waits for the wrap (R8)
   task automatic t_wrap_switch();
      start_code(0);
      for (int n = 1; n <= PERIOD + 20; n++) begin
         tick();
         if (n < PERIOD) begin
            chk("R8 old code offset", int'($signed(offset)), tb_exp(0, n));
            chk("R8 old code ratio", int'(ratio), 512);
         end else begin
            chk("R8 new code offset", int'($signed(offset)), tb_exp(4, n - PERIOD));
            chk("R8 new code ratio", int'(ratio), 1192);
         end
         if (n == 5) fsel = 3'd4;
      end
   endtask

   // restart pin edge, new code taken at the origin (R7)
   task automatic t_restart();
      start_code(0);
      for (int n = 1; n <= 11; n++) begin
         tick();
         chk("R7 before restart", int'($signed(offset)), tb_exp(0, n));
      end
      restart = 1'b1;
      fsel = 3'd6;
      for (int n = 12; n <= 13; n++) begin
         tick();
         chk("R7 sweep continues during sync", int'($signed(offset)), tb_exp(0, n));
         chk("R7 code kept during sync", int'(ratio), 512);
      end
      tick();
      chk("R7 offset at origin", int'($signed(offset)), 0);
      chk("R7 code sampled at restart", int'(ratio), 1788);
      restart = 1'b0;
      for (int n = 1; n <= 20; n++) begin
         tick();
         chk("R7 sweep after restart", int'($signed(offset)), tb_exp(6, n));
      end
   endtask

   task automatic t_power();
      pwr_dn_n = 1'b0;
      tick();
      chk("R9 mod_oe off in power-down", int'(mod_oe), 0);
      chk("R9 ref_oe off in power-down", int'(ref_oe), 0);
      repeat (2) tick();
      pwr_dn_n = 1'b1;
      for (int n = 1; n <= LK; n++) begin
         tick();
         chk("R9 mod_oe lock wait", int'(mod_oe), int'(n == LK));
         chk("R9 ref_oe lock wait", int'(ref_oe), int'(n == LK));
      end
      ref_en_n = 1'b1; test = 1'b0; #1;
      chk("R10 ref off when enable high", int'(ref_oe), 0);
      chk("R10 mod on when test low", int'(mod_oe), 1);
      test = 1'b1; #1;
      chk("R10 mod off with test and ref_en high", int'(mod_oe), 0);
      ref_en_n = 1'b0; #1;
      chk("R10 mod on with ref_en low", int'(mod_oe), 1);
      chk("R10 ref on with ref_en low", int'(ref_oe), 1);
      test = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_centre_after_reset();
      t_code(1);
      t_code(2);
      t_code(3);
      t_code(4);
      t_code(5);
      t_code(6);
      t_code(7);
      t_wrap_switch();
      t_restart();
      t_power();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule